// File: doc/BRIEF.md
# Interrupt acceptance sequencer

This block sits beside a small 8-bit processor core. It holds one request latch for each maskable source and one for a pseudo non-maskable source. At each instruction boundary it chooses the most urgent request that may be taken. It then runs a fixed eight-cycle entry sequence: three bytes go onto a downward-growing byte stack, a 16-bit handler address is fetched from a vector slot, and PC and SP are loaded. The core is stalled while `busy_o` is high.

The block also runs the two return instructions. Each return pops the saved bytes in reverse order and reloads PC, the status word and SP. The master interrupt enable travels inside the pushed status byte, so a return brings back the enable state that was in force before the interrupt. The non-maskable return also lifts the block that non-maskable entry puts on all further interrupts.

Top module: `irq_accept_seq`

## Requirements
- R1: A pulse on a request line sets that source's latch. The latch holds until the source is accepted, `il_clr_i` clears it, or reset. A request and a software clear on the same source in the same cycle leave the latch set.
- R2: Entry starts only on a clock edge where `boundary_i` is high, the block is idle and a request may be taken. `busy_o` is then high for exactly 8 cycles, beginning the cycle after that edge. Outside entry cycles 1 to 6 the memory port and load strobes stay quiet.
- R3: The entry edge clears the master enable (`imf_o`) and the accepted source's latch. A new request on that same source in that same edge keeps the latch set.
- R4: Entry cycles 1, 2 and 3 write bytes at SP, SP-1 and SP-2. The bytes are, in order: the status byte, PC[15:8] and PC[7:0]. The status byte is `psw_i` with bit IMF_POS (default 5) replaced by the master enable value from before entry.
- R5: Entry cycles 4 and 5 read the slot address and slot+1. The slot is VEC_BASE (default 0xFFFE) minus 2·n, where n is 0 for the non-maskable source and i+1 for maskable source i. In cycle 6, PC is loaded with {byte at slot+1, byte at slot} and SP is loaded with SP-3.
- R6: The non-maskable request beats every maskable one. Among maskable requests that are both latched and enabled, the lowest index wins.
- R7: A maskable request is never taken while `imf_o` is 0 or while its enable bit is 0. The non-maskable request is taken even when `imf_o` is 0.
- R8: Inside a handler, setting the master enable allows an enabled pending request to be taken, which nests one frame deeper.
- R9: After non-maskable entry, `nmi_blk_o` is 1 and no interrupt of any kind is taken until the non-maskable return finishes. That return clears `nmi_blk_o`.
- R10: A return keeps `busy_o` high for 4 cycles. Cycles 1, 2 and 3 read SP+1 (PC low), SP+2 (PC high) and SP+3 (status). Cycle 4 loads PC, the status word and SP+3. When it ends, `imf_o` takes bit IMF_POS of the popped status byte.
- R11: A return strobe on the same edge as a boundary takes precedence over entry, and the pending request stays latched. Return strobes that arrive while the block is busy are ignored.
- R12: Reset clears all latches, the enable bits, the master enable and the non-maskable block, and leaves the block idle with no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| irq_req_i | input | NSRC | Maskable request pulses |
| il_clr_i | input | NSRC | Software clear of individual latches |
| ien_we_i | input | 1 | Write strobe for the per-source enable bits |
| ien_wdata_i | input | NSRC | Enable bits to write |
| imf_set_i | input | 1 | Set the master enable |
| imf_clr_i | input | 1 | Clear the master enable |
| boundary_i | input | 1 | Current instruction has finished |
| reti_i | input | 1 | Start maskable return |
| retn_i | input | 1 | Start non-maskable return |
| pc_i | input | 16 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| psw_i | input | 8 | Current status word |
| mem_addr_o | output | 16 | Byte address for stack or vector access |
| mem_wdata_o | output | 8 | Byte to write |
| mem_we_o | output | 1 | Write strobe |
| mem_re_o | output | 1 | Read strobe (data returned in the same cycle) |
| mem_rdata_i | input | 8 | Read data |
| pc_ld_o | output | 1 | Load PC |
| pc_val_o | output | 16 | New PC |
| sp_ld_o | output | 1 | Load SP |
| sp_val_o | output | 16 | New SP |
| psw_ld_o | output | 1 | Load status word |
| psw_val_o | output | 8 | New status word |
| busy_o | output | 1 | Entry or return in progress, core stalls |
| imf_o | output | 1 | Master enable |
| nmi_blk_o | output | 1 | Interrupts blocked by non-maskable service |
| ien_o | output | NSRC | Per-source enable bits |
| il_o | output | NSRC | Maskable request latches |
| nmi_il_o | output | 1 | Non-maskable request latch |

## Verification
Two latch updates can land on the same bit in the same edge: the clear that entry applies to the winning source, and a fresh request on that source. The bench raises the accepted source's request in the very cycle `boundary_i` is high, then expects the latch to read 1 once the eight-cycle entry is done. The same collision is provoked between a software clear and a request. The bench also drives a return strobe together with a boundary while a request is pending and enabled. It expects the pop sequence (reads at SP+1 upward, no writes) and a latch that stays set.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  parameter int ADDR_W = 16;
  parameter int DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ACC, SQ_RET} sq_state_e;

  localparam int ACC_CYCLES = 8;
  localparam int RET_CYCLES = 4;

  // Vector slot of source number n (0 = non-maskable)
  function automatic addr_t vec_slot(addr_t base, int unsigned n);
    return base - addr_t'(2 * n);
  endfunction

  // Stack address at a signed byte offset from a stack pointer
  function automatic addr_t stk_at(addr_t sp, int d);
    return sp + addr_t'(d);
  endfunction

  // Status byte as pushed: master enable folded into one bit
  function automatic byte_t stat_pack(byte_t psw, logic imf, int unsigned pos);
    byte_t r;
    r      = psw;
    r[pos] = imf;
    return r;
  endfunction
endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req_i,
  input  logic            nmi_req_i,
  input  logic [NSRC-1:0] il_clr_i,
  input  logic            ien_we_i,
  input  logic [NSRC-1:0] ien_wdata_i,
  input  logic            imf_set_i,
  input  logic            imf_clr_i,
  input  logic            acc_fire_i,
  input  logic            acc_nmi_i,
  input  logic [NSRC-1:0] acc_onehot_i,
  input  logic            ret_fire_i,
  input  logic            ret_nmi_i,
  input  logic            ret_imf_i,
  output logic [NSRC-1:0] il_o,
  output logic [NSRC-1:0] ien_o,
  output logic            imf_o,
  output logic            nmi_il_o,
  output logic            nmi_blk_o
);
  // One latch per maskable source; a request in the same edge wins over any clear
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic lat_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            lat_q <= 1'b0;
      else if (irq_req_i[i])                                 lat_q <= 1'b1;
      else if (il_clr_i[i] || (acc_fire_i && acc_onehot_i[i])) lat_q <= 1'b0;
    end
    assign il_o[i] = lat_q;
  end

  logic [NSRC-1:0] ien_q;
  logic            imf_q, nmi_il_q, nmi_blk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q     <= '0;
      imf_q     <= 1'b0;
      nmi_il_q  <= 1'b0;
      nmi_blk_q <= 1'b0;
    end else begin
      if (ien_we_i) ien_q <= ien_wdata_i;

      if (nmi_req_i)                      nmi_il_q <= 1'b1;
      else if (acc_fire_i && acc_nmi_i)   nmi_il_q <= 1'b0;

      if (acc_fire_i)      imf_q <= 1'b0;
      else if (ret_fire_i) imf_q <= ret_imf_i;
      else if (imf_clr_i)  imf_q <= 1'b0;
      else if (imf_set_i)  imf_q <= 1'b1;

      if (acc_fire_i && acc_nmi_i)      nmi_blk_q <= 1'b1;
      else if (ret_fire_i && ret_nmi_i) nmi_blk_q <= 1'b0;
    end
  end

  assign ien_o     = ien_q;
  assign imf_o     = imf_q;
  assign nmi_il_o  = nmi_il_q;
  assign nmi_blk_o = nmi_blk_q;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC  = 4,
  parameter int IDX_W = $clog2(NSRC + 1)
) (
  input  logic [NSRC-1:0]  il_i,
  input  logic [NSRC-1:0]  ien_i,
  input  logic             imf_i,
  input  logic             nmi_il_i,
  input  logic             nmi_blk_i,
  output logic             win_valid_o,
  output logic             win_nmi_o,
  output logic [NSRC-1:0]  win_onehot_o,
  output logic [IDX_W-1:0] win_num_o
);
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] oh;
  logic [IDX_W-1:0] num;
  logic            found;

  assign pend = il_i & ien_i & {NSRC{imf_i & ~nmi_blk_i}};

  always_comb begin
    oh    = '0;
    num   = '0;
    found = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (!found && pend[i]) begin
        oh[i] = 1'b1;
        num   = IDX_W'(i + 1);
        found = 1'b1;
      end
    end
  end

  assign win_nmi_o    = nmi_il_i & ~nmi_blk_i;
  assign win_valid_o  = win_nmi_o | found;
  assign win_onehot_o = win_nmi_o ? '0 : oh;
  assign win_num_o    = win_nmi_o ? '0 : num;
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
#(
  parameter int    IDX_W    = 3,
  parameter addr_t VEC_BASE = 16'hFFFE,
  parameter int    IMF_POS  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary_i,
  input  logic             reti_i,
  input  logic             retn_i,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_num_i,
  input  addr_t            pc_i,
  input  addr_t            sp_i,
  input  byte_t            psw_i,
  input  logic             imf_i,
  input  byte_t            mem_rdata_i,
  output logic             acc_fire_o,
  output logic             ret_fire_o,
  output logic             ret_nmi_o,
  output logic             ret_imf_o,
  output addr_t            mem_addr_o,
  output byte_t            mem_wdata_o,
  output logic             mem_we_o,
  output logic             mem_re_o,
  output logic             pc_ld_o,
  output addr_t            pc_val_o,
  output logic             sp_ld_o,
  output addr_t            sp_val_o,
  output logic             psw_ld_o,
  output byte_t            psw_val_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(ACC_CYCLES);
  localparam int HB    = DATA_W;

  sq_state_e  st_q;
  logic [CNT_W-1:0] cnt_q;
  addr_t      sp_q, pc_q, slot_q;
  byte_t      stat_q, b_lo, b_hi, b_st;
  logic       nmi_q;
  logic       ret_start, acc_last, ret_last;

  assign ret_start  = (st_q == SQ_IDLE) && (reti_i || retn_i);
  assign acc_fire_o = (st_q == SQ_IDLE) && boundary_i && win_valid_i && !(reti_i || retn_i);
  assign acc_last   = (st_q == SQ_ACC) && (cnt_q == CNT_W'(ACC_CYCLES - 1));
  assign ret_last   = (st_q == SQ_RET) && (cnt_q == CNT_W'(RET_CYCLES - 1));
  assign ret_fire_o = ret_last;
  assign ret_nmi_o  = nmi_q;
  assign ret_imf_o  = b_st[IMF_POS];
  assign busy_o     = (st_q != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      cnt_q  <= '0;
      sp_q   <= '0;
      pc_q   <= '0;
      slot_q <= '0;
      stat_q <= '0;
      b_lo   <= '0;
      b_hi   <= '0;
      b_st   <= '0;
      nmi_q  <= 1'b0;
    end else begin
      unique case (st_q)
        SQ_IDLE: begin
          cnt_q <= '0;
          if (ret_start) begin
            st_q  <= SQ_RET;
            sp_q  <= sp_i;
            nmi_q <= retn_i;
          end else if (acc_fire_o) begin
            st_q   <= SQ_ACC;
            sp_q   <= sp_i;
            pc_q   <= pc_i;
            stat_q <= stat_pack(psw_i, imf_i, IMF_POS);
            slot_q <= vec_slot(VEC_BASE, int'(win_num_i));
          end
        end
        SQ_ACC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(3)) b_lo <= mem_rdata_i;
          if (cnt_q == CNT_W'(4)) b_hi <= mem_rdata_i;
          if (acc_last) st_q <= SQ_IDLE;
        end
        SQ_RET: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(0)) b_lo <= mem_rdata_i;
          if (cnt_q == CNT_W'(1)) b_hi <= mem_rdata_i;
          if (cnt_q == CNT_W'(2)) b_st <= mem_rdata_i;
          if (ret_last) st_q <= SQ_IDLE;
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  // Per-phase memory and load strobes
  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    mem_we_o    = 1'b0;
    mem_re_o    = 1'b0;
    pc_ld_o     = 1'b0;
    pc_val_o    = {b_hi, b_lo};
    sp_ld_o     = 1'b0;
    sp_val_o    = '0;
    psw_ld_o    = 1'b0;
    psw_val_o   = b_st;
    if (st_q == SQ_ACC) begin
      unique case (cnt_q)
        CNT_W'(0): begin mem_we_o = 1'b1; mem_addr_o = sp_q;            mem_wdata_o = stat_q; end
        CNT_W'(1): begin mem_we_o = 1'b1; mem_addr_o = stk_at(sp_q, -1); mem_wdata_o = pc_q[ADDR_W-1:HB]; end
        CNT_W'(2): begin mem_we_o = 1'b1; mem_addr_o = stk_at(sp_q, -2); mem_wdata_o = pc_q[HB-1:0]; end
        CNT_W'(3): begin mem_re_o = 1'b1; mem_addr_o = slot_q; end
        CNT_W'(4): begin mem_re_o = 1'b1; mem_addr_o = stk_at(slot_q, 1); end
        CNT_W'(5): begin
          pc_ld_o  = 1'b1;
          sp_ld_o  = 1'b1;
          sp_val_o = stk_at(sp_q, -3);
        end
        default: ;
      endcase
    end else if (st_q == SQ_RET) begin
      unique case (cnt_q)
        CNT_W'(0): begin mem_re_o = 1'b1; mem_addr_o = stk_at(sp_q, 1); end
        CNT_W'(1): begin mem_re_o = 1'b1; mem_addr_o = stk_at(sp_q, 2); end
        CNT_W'(2): begin mem_re_o = 1'b1; mem_addr_o = stk_at(sp_q, 3); end
        CNT_W'(3): begin
          pc_ld_o  = 1'b1;
          psw_ld_o = 1'b1;
          sp_ld_o  = 1'b1;
          sp_val_o = stk_at(sp_q, 3);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq
  import irq_seq_pkg::*;
#(
  parameter int    NSRC     = 4,
  parameter addr_t VEC_BASE = 16'hFFFE,
  parameter int    IMF_POS  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req_i,
  input  logic [NSRC-1:0]   irq_req_i,
  input  logic [NSRC-1:0]   il_clr_i,
  input  logic              ien_we_i,
  input  logic [NSRC-1:0]   ien_wdata_i,
  input  logic              imf_set_i,
  input  logic              imf_clr_i,
  input  logic              boundary_i,
  input  logic              reti_i,
  input  logic              retn_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [DATA_W-1:0] psw_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              pc_ld_o,
  output logic [ADDR_W-1:0] pc_val_o,
  output logic              sp_ld_o,
  output logic [ADDR_W-1:0] sp_val_o,
  output logic              psw_ld_o,
  output logic [DATA_W-1:0] psw_val_o,
  output logic              busy_o,
  output logic              imf_o,
  output logic              nmi_blk_o,
  output logic [NSRC-1:0]   ien_o,
  output logic [NSRC-1:0]   il_o,
  output logic              nmi_il_o
);
  localparam int IDX_W = $clog2(NSRC + 1);

  // Named internal events
  logic             acc_fire, ret_fire, ret_nmi, ret_imf;
  logic             win_valid, win_nmi;
  logic [NSRC-1:0]  win_onehot;
  logic [IDX_W-1:0] win_num;

  irq_latch_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .irq_req_i(irq_req_i), .nmi_req_i(nmi_req_i), .il_clr_i(il_clr_i),
    .ien_we_i(ien_we_i), .ien_wdata_i(ien_wdata_i),
    .imf_set_i(imf_set_i), .imf_clr_i(imf_clr_i),
    .acc_fire_i(acc_fire), .acc_nmi_i(win_nmi), .acc_onehot_i(win_onehot),
    .ret_fire_i(ret_fire), .ret_nmi_i(ret_nmi), .ret_imf_i(ret_imf),
    .il_o(il_o), .ien_o(ien_o), .imf_o(imf_o),
    .nmi_il_o(nmi_il_o), .nmi_blk_o(nmi_blk_o)
  );

  irq_prio_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick (
    .il_i(il_o), .ien_i(ien_o), .imf_i(imf_o),
    .nmi_il_i(nmi_il_o), .nmi_blk_i(nmi_blk_o),
    .win_valid_o(win_valid), .win_nmi_o(win_nmi),
    .win_onehot_o(win_onehot), .win_num_o(win_num)
  );

  irq_seq_fsm #(.IDX_W(IDX_W), .VEC_BASE(VEC_BASE), .IMF_POS(IMF_POS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .boundary_i(boundary_i), .reti_i(reti_i), .retn_i(retn_i),
    .win_valid_i(win_valid), .win_num_i(win_num),
    .pc_i(pc_i), .sp_i(sp_i), .psw_i(psw_i), .imf_i(imf_o),
    .mem_rdata_i(mem_rdata_i),
    .acc_fire_o(acc_fire), .ret_fire_o(ret_fire),
    .ret_nmi_o(ret_nmi), .ret_imf_o(ret_imf),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .pc_ld_o(pc_ld_o), .pc_val_o(pc_val_o),
    .sp_ld_o(sp_ld_o), .sp_val_o(sp_val_o),
    .psw_ld_o(psw_ld_o), .psw_val_o(psw_val_o),
    .busy_o(busy_o)
  );

  assert_accept_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |-> (boundary_i && !busy_o));

  assert_imf_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !imf_o);

  assert_latch_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !win_nmi && ((win_onehot & irq_req_i) == '0))
      |=> ((il_o & $past(win_onehot)) == '0));

  assert_port_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && !win_nmi) |-> (imf_o && !nmi_blk_o));

  assert_nmi_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blk_o |-> !acc_fire);

  assert_ret_restore_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_fire |=> (imf_o == $past(ret_imf)));

  assert_pc_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_o |=> !pc_ld_o);
endmodule

// File: tb/irq_accept_seq_tb_top.sv
`timescale 1ns/1ps
module irq_accept_seq_tb_top;
  localparam int NSRC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            nmi_req = 1'b0, ien_we = 1'b0, imf_set = 1'b0, imf_clr = 1'b0;
  logic            boundary = 1'b0, reti = 1'b0, retn = 1'b0;
  logic [NSRC-1:0] irq_req = '0, il_clr = '0, ien_wdata = '0;
  logic [15:0]     pc, sp;
  logic [7:0]      psw;

  logic [15:0] mem_addr, pc_val, sp_val;
  logic [7:0]  mem_wdata, mem_rdata, psw_val;
  logic        mem_we, mem_re, pc_ld, sp_ld, psw_ld, busy, imf, nmi_blk, nmi_il;
  logic [NSRC-1:0] ien, il;

  irq_accept_seq #(.NSRC(NSRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_req_i(nmi_req), .irq_req_i(irq_req),
    .il_clr_i(il_clr), .ien_we_i(ien_we), .ien_wdata_i(ien_wdata),
    .imf_set_i(imf_set), .imf_clr_i(imf_clr), .boundary_i(boundary),
    .reti_i(reti), .retn_i(retn), .pc_i(pc), .sp_i(sp), .psw_i(psw),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_re_o(mem_re), .mem_rdata_i(mem_rdata),
    .pc_ld_o(pc_ld), .pc_val_o(pc_val), .sp_ld_o(sp_ld), .sp_val_o(sp_val),
    .psw_ld_o(psw_ld), .psw_val_o(psw_val), .busy_o(busy), .imf_o(imf),
    .nmi_blk_o(nmi_blk), .ien_o(ien), .il_o(il), .nmi_il_o(nmi_il)
  );

  // Memory model: page 0xFF holds vectors, everything else is stack
  logic [7:0] vec_mem [256];
  logic [7:0] stk_mem [256];
  initial begin
    for (int k = 0; k < 256; k++) vec_mem[k] = 8'h00;
    for (int n = 0; n <= NSRC; n++) begin
      vec_mem[8'hFE - 8'(2 * n)] = 8'h10 + 8'(n);
      vec_mem[8'hFF - 8'(2 * n)] = 8'hA0 + 8'(n);
    end
  end
  assign mem_rdata = (mem_addr[15:8] == 8'hFF) ? vec_mem[mem_addr[7:0]] : stk_mem[mem_addr[7:0]];

  // Core model: registers follow the load strobes
  always @(posedge clk) begin
    if (!rst_n) begin
      pc  <= 16'h1234;
      sp  <= 16'h0080;
      psw <= 8'h0C;
    end else begin
      if (mem_we && mem_addr[15:8] != 8'hFF) stk_mem[mem_addr[7:0]] <= mem_wdata;
      if (pc_ld)  pc  <= pc_val;
      if (sp_ld)  sp  <= sp_val;
      if (psw_ld) psw <= psw_val;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [15:0] fr_pc [8];
  logic [7:0]  fr_st [8];
  int depth = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_imf_set();
    imf_set = 1'b1; tick(1); imf_set = 1'b0;
  endtask

  task automatic write_ien(input logic [NSRC-1:0] v);
    ien_we = 1'b1; ien_wdata = v; tick(1); ien_we = 1'b0;
  endtask

  task automatic pulse_req(input logic [NSRC-1:0] v);
    irq_req = v; tick(1); irq_req = '0;
  endtask

  task automatic expect_no_accept(input string req);
    boundary = 1'b1; tick(1); boundary = 1'b0;
    chk({req, " no entry busy"}, busy, 0);
    chk({req, " no entry write"}, mem_we, 0);
    tick(1);
  endtask

  // Entry of source number n (0 = non-maskable, i+1 = maskable i)
  task automatic do_accept(input int n, input logic [NSRC-1:0] edge_req,
                           input bit poke_ret, input string req);
    logic [15:0] sp0, pc0, slot, entry;
    logic [7:0]  st;
    sp0 = sp; pc0 = pc;
    st = psw; st[5] = imf;
    slot  = 16'hFFFE - 16'(2 * n);
    entry = {8'hA0 + 8'(n), 8'h10 + 8'(n)};
    boundary = 1'b1; irq_req = edge_req;
    tick(1);
    boundary = 1'b0; irq_req = '0;
    for (int c = 1; c <= 8; c++) begin
      chk({req, " R2 busy during entry"}, busy, 1);
      case (c)
        1: begin
          chk({req, " R4 push status"}, {mem_we, mem_addr, mem_wdata}, {1'b1, sp0, st});
          chk({req, " R3 imf cleared"}, imf, 0);
        end
        2: chk({req, " R4 push pc high"}, {mem_we, mem_addr, mem_wdata}, {1'b1, sp0 - 16'd1, pc0[15:8]});
        3: chk({req, " R4 push pc low"},  {mem_we, mem_addr, mem_wdata}, {1'b1, sp0 - 16'd2, pc0[7:0]});
        4: chk({req, " R5 vector low read"},  {mem_re, mem_addr}, {1'b1, slot});
        5: chk({req, " R5 vector high read"}, {mem_re, mem_addr}, {1'b1, slot + 16'd1});
        6: chk({req, " R5 pc/sp load"}, {pc_ld, pc_val, sp_ld, sp_val}, {1'b1, entry, 1'b1, sp0 - 16'd3});
        default: chk({req, " R2 quiet tail"}, {mem_we, mem_re, pc_ld, sp_ld}, 4'b0);
      endcase
      reti = poke_ret && (c == 2);
      tick(1);
    end
    reti = 1'b0;
    chk({req, " R2 entry length"}, busy, 0);
    chk({req, " R5 pc entry"}, pc, entry);
    chk({req, " R5 sp minus 3"}, sp, sp0 - 16'd3);
    fr_pc[depth] = pc0; fr_st[depth] = st; depth++;
  endtask

  task automatic do_return(input bit nmi, input bit with_boundary, input string req);
    logic [15:0] sp0, epc;
    logic [7:0]  est;
    sp0 = sp;
    depth--;
    epc = fr_pc[depth]; est = fr_st[depth];
    if (nmi) retn = 1'b1; else reti = 1'b1;
    boundary = with_boundary;
    tick(1);
    retn = 1'b0; reti = 1'b0; boundary = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      chk({req, " R10 busy during return"}, busy, 1);
      if (c < 4) begin
        chk({req, " R10 pop read"}, {mem_re, mem_addr}, {1'b1, sp0 + 16'(c)});
        chk({req, " R11 no push on return"}, mem_we, 0);
      end else begin
        chk({req, " R10 restore loads"}, {pc_ld, pc_val, psw_ld, psw_val, sp_ld, sp_val},
            {1'b1, epc, 1'b1, est, 1'b1, sp0 + 16'd3});
      end
      tick(1);
    end
    chk({req, " R10 return length"}, busy, 0);
    chk({req, " R10 imf restored"}, imf, est[5]);
    chk({req, " R10 sp plus 3"}, sp, sp0 + 16'd3);
  endtask

  initial begin
    // R12: reset state
    tick(2);
    chk("R12 reset busy", busy, 0);
    chk("R12 reset latches", {il, nmi_il}, 0);
    chk("R12 reset enables", ien, 0);
    chk("R12 reset imf/block", {imf, nmi_blk}, 0);
    chk("R12 reset memory quiet", {mem_we, mem_re}, 0);
    rst_n = 1'b1;
    tick(2);

    // R1: latch behaviour
    write_ien('1);
    pulse_req(4'b0100);
    chk("R1 latch set", il, 4'b0100);
    tick(3);
    chk("R1 latch held", il, 4'b0100);
    il_clr = 4'b0100; tick(1); il_clr = '0;
    chk("R1 software clear", il, 0);
    irq_req = 4'b0100; il_clr = 4'b0100; tick(1); irq_req = '0; il_clr = '0;
    chk("R1 request beats clear", il, 4'b0100);

    // R7: master enable and per-source enable gate maskable requests
    expect_no_accept("R7 imf low");
    chk("R1 still pending", il, 4'b0100);
    pulse_imf_set();
    chk("R7 imf set", imf, 1);
    write_ien(4'b1011);
    expect_no_accept("R7 source disabled");
    write_ien('1);

    // R4 R5: basic entry of source 2
    do_accept(3, '0, 1'b0, "R5 basic");
    chk("R3 latch cleared on entry", il, 0);

    // R6: lowest index wins, gated by imf first
    pulse_req(4'b1010);
    chk("R1 two latches", il, 4'b1010);
    expect_no_accept("R7 higher priority still masked");
    pulse_imf_set();
    do_accept(2, '0, 1'b0, "R6 lowest index");
    chk("R6 loser stays pending", il, 4'b1000);

    // R8 nesting, R11 return strobe during busy ignored
    pulse_imf_set();
    do_accept(4, '0, 1'b1, "R8 nested");
    chk("R8 nested latch cleared", il, 0);
    do_return(1'b0, 1'b0, "R10 inner");
    do_return(1'b0, 1'b0, "R10 middle");
    do_return(1'b0, 1'b0, "R10 outer");

    // R3 collision: new request on the accepted source in the entry edge
    pulse_req(4'b0001);
    do_accept(1, 4'b0001, 1'b0, "R3 collision");
    chk("R3 re-request survives clear", il, 4'b0001);
    pulse_imf_set();
    do_return(1'b0, 1'b1, "R11 return with boundary");
    chk("R11 pending kept after return", il, 4'b0001);
    do_accept(1, '0, 1'b0, "R6 source 0");
    do_return(1'b0, 1'b0, "R10 source 0");

    // R9: non-maskable entry and blocking
    imf_clr = 1'b1; tick(1); imf_clr = 1'b0;
    nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
    chk("R1 nmi latch", nmi_il, 1);
    do_accept(0, '0, 1'b0, "R7 nmi with imf low");
    chk("R9 block set", nmi_blk, 1);
    chk("R3 nmi latch cleared", nmi_il, 0);
    pulse_imf_set();
    pulse_req(4'b0100);
    expect_no_accept("R9 maskable blocked");
    nmi_req = 1'b1; tick(1); nmi_req = 1'b0;
    expect_no_accept("R9 nmi blocked");
    do_return(1'b1, 1'b0, "R9 nmi return");
    chk("R9 block lifted", nmi_blk, 0);
    do_accept(0, '0, 1'b0, "R6 nmi beats maskable");
    do_return(1'b1, 1'b0, "R10 nmi return");
    pulse_imf_set();
    do_accept(3, '0, 1'b0, "R6 pending maskable");
    do_return(1'b0, 1'b0, "R10 final");
    chk("R1 all latches idle", {il, nmi_il}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R2 act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule